// File: doc/BRIEF.md
# Conditional Jump Evaluation Unit

This block decides whether a relative branch word in a 16-bit microcontroller core is taken, and computes where execution continues. Each cycle that its input strobe is high, it takes one instruction word, the address of the word that follows that instruction, and the four status flags (carry, zero, negative, overflow). It then decides whether the word is a relative branch and whether the branch condition holds, and it forms the next fetch address.

A word is a branch when its three top bits read 001. A three-bit field selects one of eight conditions. A ten-bit signed word offset, doubled, is added to the supplied address. The result is registered: the decision, the next address and an output strobe appear one clock after the input strobe. Fetch, the register file and flag generation are handled outside this block.

Top module: `jump_eval_unit`

## Requirements
- R1: A synchronous active-high reset clears the output strobe `res_valid`, the taken flag and the next-address output to zero.
- R2: `res_valid` is high exactly in the cycle after a cycle in which `in_valid` was high. The taken flag and next address also update only in that cycle and hold their values otherwise.
- R3: A word is treated as a branch only when bits [15:13] equal 3'b001. Any other word gives taken = 0 and next address = input PC.
- R4: For a branch word, bits [12:10] select the condition: 0 taken when Z=0, 1 when Z=1, 2 when C=0, 3 when C=1, 4 when N=1, 7 always.
- R5: Condition 5 (signed greater-or-equal) is taken when N equals V. Condition 6 (signed less) is taken when N differs from V.
- R6: The taken target is the input PC plus twice the sign-extended ten-bit offset in bits [9:0], wrapped modulo 2^16. Offset 0x1FF gives +1022 and 0x200 gives -1024.
- R7: A branch that is not taken outputs next address = input PC.
- R8: Bit 0 of a taken target is always 0 when the input PC is even.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word strobe |
| instr | input | 16 | Instruction word |
| pc_in | input | 16 | Address of the word after the instruction |
| flag_c | input | 1 | Carry flag |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| res_valid | output | 1 | Result strobe, one cycle after in_valid |
| res_taken | output | 1 | Branch taken |
| res_next_pc | output | 16 | Next fetch address |

## Verification
The hardest cases to reach are the arithmetic corners of the offset: the most negative and most positive offsets, and wrap-around through address zero and through 0xFFFF. Each of these needs a specific PC paired with a specific offset. Table rows place the PC next to these boundaries and use the unconditional condition so that only the arithmetic is under test. Each signed-compare condition is driven with all four N/V combinations, so that N alone cannot produce a false pass.

// File: rtl/jump_eval_pkg.sv
package jump_eval_pkg;
  localparam int WORD_W = 16;
  localparam int OFF_W  = 10;
  localparam int COND_W = 3;

  typedef enum logic [COND_W-1:0] {
    CND_NZ  = 3'd0,
    CND_Z   = 3'd1,
    CND_NC  = 3'd2,
    CND_C   = 3'd3,
    CND_NEG = 3'd4,
    CND_GE  = 3'd5,
    CND_LT  = 3'd6,
    CND_ALW = 3'd7
  } cond_e;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } flags_t;
endpackage

// File: rtl/jump_decode.sv
module jump_decode
  import jump_eval_pkg::*;
#(
  parameter int W     = WORD_W,
  parameter int OW    = OFF_W,
  parameter int CW    = COND_W,
  parameter int TAG_W = W - CW - OW
) (
  input  logic [W-1:0]     word,
  output logic             is_jump,
  output cond_e            cond,
  output logic [OW-1:0]    offset
);
  localparam logic [TAG_W-1:0] JUMP_TAG = TAG_W'(1);

  always_comb begin
    is_jump = (word[W-1 -: TAG_W] == JUMP_TAG);
    cond    = cond_e'(word[OW +: CW]);
    offset  = word[OW-1:0];
  end
endmodule

// File: rtl/jump_cond.sv
module jump_cond
  import jump_eval_pkg::*;
(
  input  cond_e  cond,
  input  flags_t fl,
  output logic   pass
);
  always_comb begin
    unique case (cond)
      CND_NZ:  pass = ~fl.z;
      CND_Z:   pass =  fl.z;
      CND_NC:  pass = ~fl.c;
      CND_C:   pass =  fl.c;
      CND_NEG: pass =  fl.n;
      CND_GE:  pass = ~(fl.n ^ fl.v);
      CND_LT:  pass =  (fl.n ^ fl.v);
      default: pass = 1'b1;
    endcase
  end
endmodule

// File: rtl/jump_target.sv
module jump_target #(
  parameter int W  = 16,
  parameter int OW = 10
) (
  input  logic [W-1:0]  pc,
  input  logic [OW-1:0] offset,
  output logic [W-1:0]  target
);
  logic [W-1:0] disp;
  always_comb begin
    disp   = {{(W-OW-1){offset[OW-1]}}, offset, 1'b0};
    target = pc + disp;
  end
endmodule

// File: rtl/jump_eval_unit.sv
module jump_eval_unit
  import jump_eval_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [15:0] instr,
  input  logic [15:0] pc_in,
  input  logic        flag_c,
  input  logic        flag_z,
  input  logic        flag_n,
  input  logic        flag_v,
  output logic        res_valid,
  output logic        res_taken,
  output logic [15:0] res_next_pc
);
  logic               is_jump;
  cond_e              cond;
  logic [OFF_W-1:0]   offset;
  logic               pass;
  logic [WORD_W-1:0]  target;
  logic               take;
  flags_t             fl;

  assign fl = '{c: flag_c, z: flag_z, n: flag_n, v: flag_v};

  jump_decode u_dec (.word(instr), .is_jump(is_jump), .cond(cond), .offset(offset));
  jump_cond   u_cnd (.cond(cond), .fl(fl), .pass(pass));
  jump_target #(.W(WORD_W), .OW(OFF_W)) u_tgt (.pc(pc_in), .offset(offset), .target(target));

  assign take = is_jump & pass;

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid   <= 1'b0;
      res_taken   <= 1'b0;
      res_next_pc <= '0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) begin
        res_taken   <= take;
        res_next_pc <= take ? target : pc_in;
      end
    end
  end

  // R2: output strobe follows input strobe by one cycle
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    res_valid == $past(in_valid));
  // R2: results hold when no new input was accepted
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid) && !$past(rst) |-> $stable(res_next_pc) && $stable(res_taken));
  // R3: non-branch words never taken, address passes through
  a_r3_nonjump: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid) && $past(instr[15:13]) != 3'b001 |-> !res_taken && res_next_pc == $past(pc_in));
  // R7: not taken yields input address
  a_r7_fallthrough: assert property (@(posedge clk) disable iff (rst)
    res_valid && !res_taken |-> res_next_pc == $past(pc_in));
  // R4: unconditional branch is always taken
  a_r4_always: assert property (@(posedge clk) disable iff (rst)
    $past(in_valid) && $past(instr[15:10]) == 6'b001111 |-> res_taken);
  // R8: even base gives even target
  a_r8_even: assert property (@(posedge clk) disable iff (rst)
    res_valid && res_taken && !$past(pc_in[0]) |-> !res_next_pc[0]);
endmodule

// File: tb/jump_eval_unit_bench.sv
module jump_eval_unit_bench;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0;
  logic [15:0] instr = '0, pc_in = '0;
  logic flag_c = 0, flag_z = 0, flag_n = 0, flag_v = 0;
  logic res_valid, res_taken;
  logic [15:0] res_next_pc;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  jump_eval_unit u_jump_eval_unit (.*);

  // vector: instr, pc, flags{c,z,n,v}, exp_taken, exp_pc
  typedef struct packed {
    logic [15:0] ins; logic [15:0] pc; logic [3:0] f; logic tk; logic [15:0] npc;
  } vec_t;
  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{16'h2005, 16'h1000, 4'b0000, 1'b1, 16'h100A}, // R4 NZ taken
    '{16'h2005, 16'h1000, 4'b0100, 1'b0, 16'h1000}, // R4 NZ not
    '{16'h2405, 16'h1000, 4'b0100, 1'b1, 16'h100A}, // R4 Z
    '{16'h2405, 16'h1000, 4'b0000, 1'b0, 16'h1000},
    '{16'h2803, 16'h2000, 4'b0000, 1'b1, 16'h2006}, // R4 NC
    '{16'h2803, 16'h2000, 4'b1000, 1'b0, 16'h2000},
    '{16'h2C03, 16'h2000, 4'b1000, 1'b1, 16'h2006}, // R4 C
    '{16'h2C03, 16'h2000, 4'b0111, 1'b0, 16'h2000},
    '{16'h3001, 16'h3000, 4'b0010, 1'b1, 16'h3002}, // R4 NEG
    '{16'h3001, 16'h3000, 4'b1101, 1'b0, 16'h3000},
    '{16'h3402, 16'h4000, 4'b0000, 1'b1, 16'h4004}, // R5 GE n=v=0
    '{16'h3402, 16'h4000, 4'b0011, 1'b1, 16'h4004}, // R5 GE n=v=1
    '{16'h3402, 16'h4000, 4'b0010, 1'b0, 16'h4000}, // R5 GE n only
    '{16'h3402, 16'h4000, 4'b0001, 1'b0, 16'h4000}, // R5 GE v only
    '{16'h3802, 16'h4000, 4'b0010, 1'b1, 16'h4004}, // R5 LT
    '{16'h3802, 16'h4000, 4'b0001, 1'b1, 16'h4004},
    '{16'h3802, 16'h4000, 4'b0011, 1'b0, 16'h4000},
    '{16'h3802, 16'h4000, 4'b0000, 1'b0, 16'h4000},
    '{16'h3DFF, 16'h8000, 4'b0000, 1'b1, 16'h83FE}, // R6 +1022
    '{16'h3E00, 16'h8000, 4'b0000, 1'b1, 16'h7C00}, // R6 -1024
    '{16'h3FFF, 16'h0000, 4'b0000, 1'b1, 16'hFFFE}, // R6 wrap below 0
    '{16'h3C04, 16'hFFFC, 4'b0000, 1'b1, 16'h0004}, // R6 wrap above FFFF
    '{16'h4031, 16'h1234, 4'b1111, 1'b0, 16'h1234}, // R3 MOV word
    '{16'h1000, 16'h5678, 4'b0000, 1'b0, 16'h5678}  // R3 other format
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] i, input logic [15:0] p, input logic [3:0] f);
    @(negedge clk);
    instr = i; pc_in = p; {flag_c, flag_z, flag_n, flag_v} = f; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", res_valid, 0);
    chk("R1 taken", res_taken, 0);
    chk("R1 pc", res_next_pc, 0);
    rst = 1'b0;
    for (int k = 0; k < NV; k++) begin
      apply(VEC[k].ins, VEC[k].pc, VEC[k].f);
      chk("R2 valid", res_valid, 1);
      chk($sformatf("R4/R5/R6/R3 taken v%0d", k), res_taken, VEC[k].tk);
      chk($sformatf("R6/R7 next pc v%0d", k), res_next_pc, VEC[k].npc);
    end
    // R2: no strobe -> outputs hold while inputs change
    apply(16'h3C10, 16'h0100, 4'b0);
    @(negedge clk);
    instr = 16'h3C01; pc_in = 16'hAAAA;
    @(negedge clk);
    chk("R2 valid low", res_valid, 0);
    chk("R2 hold pc", res_next_pc, 16'h0120);
    chk("R2 hold taken", res_taken, 1);
    // R8: taken targets even from even base
    for (int k = 0; k < 8; k++) begin
      apply(16'h3C00 | 16'(k * 37), 16'(k * 1234) & 16'hFFFE, 4'b0);
      chk("R8 even", res_next_pc[0], 0);
    end
    // R1: reset mid-stream clears
    @(negedge clk); rst = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    chk("R1 rst valid", res_valid, 0);
    chk("R1 rst pc", res_next_pc, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule